// File: doc/BRIEF.md
# Data-dependent row rotator for an image-oriented cipher round

This unit performs the row-transposition step of a modified block-cipher round. It takes a 128-bit state and treats it as a 4×4 byte matrix stored column by column. The state is permuted by rotating some of its rows. Which rows move, and in which direction, is decided on every pass by the parity of the byte at row 0, column 0. Byte values never change; only their positions do.

There are two patterns. When that byte is even, rows 0 and 3 stay where they are, row 1 rotates right by one column and row 2 rotates right by two columns. When it is odd, rows 0 and 2 stay where they are, row 1 rotates left by one column and row 3 rotates left by three columns. Row 0 is never moved, so the deciding byte survives the step. The inverse direction can therefore read the same parity from its own input and undo the rotations. A direction input selects forward or inverse. By default the permuted state is registered, which gives one cycle of latency. A parameter can turn the unit into pure combinational logic.

Top module: `rowperm_top`

## Requirements
- R1: Byte (r,c) of the matrix occupies bits [8·(4c+r)+7 : 8·(4c+r)] of both `state_i` and `state_o`.
- R2: Row 0 (bytes (0,0),(0,1),(0,2),(0,3)) of the output always equals row 0 of the input, in both directions.
- R3: Forward (`inv_i`=0) with byte (0,0) even (bit 0 of `state_i` = 0): out(1,c)=in(1,(c-1) mod 4), out(2,c)=in(2,(c-2) mod 4), and row 3 is unchanged.
- R4: Forward with byte (0,0) odd (bit 0 = 1): out(1,c)=in(1,(c+1) mod 4), out(3,c)=in(3,(c+3) mod 4), and row 2 is unchanged.
- R5: Inverse (`inv_i`=1) with byte (0,0) even: out(1,c)=in(1,(c+1) mod 4), out(2,c)=in(2,(c+2) mod 4), and rows 0 and 3 are unchanged.
- R6: Inverse with byte (0,0) odd: out(1,c)=in(1,(c-1) mod 4), out(3,c)=in(3,(c-3) mod 4), and rows 0 and 2 are unchanged.
- R7: Applying the inverse to the forward result returns the original state, for every state.
- R8: The output holds exactly the input's bytes, only moved: a state whose 16 bytes are all equal comes out unchanged, and the XOR of all 16 bytes is preserved.
- R9: With the default registered output, `state_o` reflects the input one clock edge later and holds its value between edges. While `rst_ni` is low, `state_o` is all zeros, and it clears at once when reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset, clears the output register |
| inv_i | input | 1 | 0 = forward permutation, 1 = inverse permutation |
| state_i | input | 128 | Input state, byte (r,c) at bit offset 8·(4c+r) |
| state_o | output | 128 | Permuted state, same byte layout |

## Verification
An incrementing byte pattern is applied in both directions, with byte (0,0) even. It shows exactly which column each byte of rows 1 and 2 lands in, and that row 3 stays put. A pattern of distinct odd bytes does the same for the odd case, where rows 1 and 3 rotate and row 2 stays put. A single non-zero byte confirms the bit position of one matrix entry. A uniform state exposes any byte that is dropped or duplicated. Random states are compared against an independent destination-column model. They are also passed forward and then back to confirm that the original is restored. Directed steps cover the reset value, the one-cycle latency and a reset asserted mid-run.

// File: rtl/rowperm_pkg.sv
`timescale 1ns/1ps
package rowperm_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_ROWS  = 4;
  localparam int unsigned N_COLS  = 4;  // must be a power of two
  localparam int unsigned ROT_W   = $clog2(N_COLS);
  localparam int unsigned ROW_W   = N_COLS * BYTE_W;
  localparam int unsigned STATE_W = N_ROWS * ROW_W;

  typedef logic [BYTE_W-1:0]             byte_t;
  typedef logic [N_COLS-1:0][BYTE_W-1:0] row_t;
  typedef logic [ROT_W-1:0]              rot_t;
  typedef logic [N_ROWS-1:0][ROT_W-1:0]  rot_vec_t;
endpackage

// File: rtl/rowperm_pat_sel.sv
`timescale 1ns/1ps
module rowperm_pat_sel
  import rowperm_pkg::*;
#(
  parameter int unsigned EVEN_R1 = 1,
  parameter int unsigned EVEN_R2 = 2,
  parameter int unsigned ODD_R1  = 1,
  parameter int unsigned ODD_R3  = 3
) (
  input  logic     odd_i,
  input  logic     inv_i,
  output rot_vec_t left_o
);
  // all amounts expressed as left rotations modulo N_COLS
  localparam rot_t EV1 = rot_t'(N_COLS - (EVEN_R1 % N_COLS));
  localparam rot_t EV2 = rot_t'(N_COLS - (EVEN_R2 % N_COLS));
  localparam rot_t OD1 = rot_t'(ODD_R1 % N_COLS);
  localparam rot_t OD3 = rot_t'(ODD_R3 % N_COLS);

  rot_vec_t fwd;

  always_comb begin
    fwd = '0;
    if (odd_i) begin
      fwd[1] = OD1;
      fwd[3] = OD3;
    end else begin
      fwd[1] = EV1;
      fwd[2] = EV2;
    end
  end

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    assign left_o[r] = inv_i ? (rot_t'(0) - fwd[r]) : fwd[r];
  end
endmodule

// File: rtl/rowperm_row_rot.sv
`timescale 1ns/1ps
module rowperm_row_rot
  import rowperm_pkg::*;
(
  input  row_t row_i,
  input  rot_t left_i,
  output row_t row_o
);
  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    rot_t src;
    assign src      = rot_t'(c) + left_i;  // wraps modulo N_COLS
    assign row_o[c] = row_i[src];
  end
endmodule

// File: rtl/rowperm_out_stage.sv
`timescale 1ns/1ps
module rowperm_out_stage #(
  parameter bit          OUT_REG = 1'b1,
  parameter int unsigned W       = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_comb
    assign q_o = d_i;
  end
endmodule

// File: rtl/rowperm_top.sv
`timescale 1ns/1ps
module rowperm_top
  import rowperm_pkg::*;
#(
  parameter bit          OUT_REG = 1'b1,
  parameter int unsigned EVEN_R1 = 1,
  parameter int unsigned EVEN_R2 = 2,
  parameter int unsigned ODD_R1  = 1,
  parameter int unsigned ODD_R3  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               inv_i,
  input  logic [STATE_W-1:0] state_i,
  output logic [STATE_W-1:0] state_o
);
  row_t [N_ROWS-1:0]  rows_in;
  row_t [N_ROWS-1:0]  rows_out;
  rot_vec_t           left;
  logic [STATE_W-1:0] perm;

  // column-major byte layout
  for (genvar r = 0; r < N_ROWS; r++) begin : g_map_r
    for (genvar c = 0; c < N_COLS; c++) begin : g_map_c
      assign rows_in[r][c] = state_i[BYTE_W*(N_ROWS*c+r) +: BYTE_W];
      assign perm[BYTE_W*(N_ROWS*c+r) +: BYTE_W] = rows_out[r][c];
    end
  end

  rowperm_pat_sel #(
    .EVEN_R1(EVEN_R1),
    .EVEN_R2(EVEN_R2),
    .ODD_R1 (ODD_R1),
    .ODD_R3 (ODD_R3)
  ) u_sel (
    .odd_i (rows_in[0][0][0]),
    .inv_i (inv_i),
    .left_o(left)
  );

  for (genvar r = 0; r < N_ROWS; r++) begin : g_rot
    rowperm_row_rot u_rot (
      .row_i (rows_in[r]),
      .left_i(left[r]),
      .row_o (rows_out[r])
    );
  end

  rowperm_out_stage #(
    .OUT_REG(OUT_REG),
    .W      (STATE_W)
  ) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (perm),
    .q_o   (state_o)
  );
endmodule

// File: rtl/rowperm_chk.sv
`timescale 1ns/1ps
module rowperm_chk
  import rowperm_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [STATE_W-1:0] state_i,
  input logic [STATE_W-1:0] state_o
);
  function automatic logic [ROW_W-1:0] row_of(input logic [STATE_W-1:0] s, input int r);
    logic [ROW_W-1:0] v;
    for (int c = 0; c < N_COLS; c++) v[BYTE_W*c +: BYTE_W] = s[BYTE_W*(N_ROWS*c+r) +: BYTE_W];
    return v;
  endfunction

  function automatic byte_t xor_fold(input logic [STATE_W-1:0] s);
    byte_t a;
    a = '0;
    for (int k = 0; k < N_ROWS*N_COLS; k++) a ^= s[BYTE_W*k +: BYTE_W];
    return a;
  endfunction

  if (OUT_REG) begin : g_seq
    logic primed;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) primed <= 1'b0;
      else         primed <= 1'b1;
    end

    assert_row0_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed |-> row_of(state_o, 0) == $past(row_of(state_i, 0)));

    assert_even_row3_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed && !$past(state_i[0])) |-> row_of(state_o, 3) == $past(row_of(state_i, 3)));

    assert_odd_row2_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed && $past(state_i[0])) |-> row_of(state_o, 2) == $past(row_of(state_i, 2)));

    assert_bytes_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed |-> xor_fold(state_o) == $past(xor_fold(state_i)));
  end else begin : g_comb
    always @(negedge clk_i) begin
      if (rst_ni) begin
        assert_row0_kept_R2: assert (row_of(state_o, 0) == row_of(state_i, 0));
        assert_bytes_kept_R8: assert (xor_fold(state_o) == xor_fold(state_i));
        if (!state_i[0]) begin
          assert_even_row3_kept_R3: assert (row_of(state_o, 3) == row_of(state_i, 3));
        end else begin
          assert_odd_row2_kept_R4: assert (row_of(state_o, 2) == row_of(state_i, 2));
        end
      end
    end
  end
endmodule

bind rowperm_top rowperm_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .state_i(state_i),
  .state_o(state_o)
);

// File: tb/sim_rowperm_top.sv
`timescale 1ns/1ps
module sim_rowperm_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inv_r = 1'b0;
  logic [127:0] st_r = '0;
  logic [127:0] state_o;
  int           n_run = 0;
  int           n_fail = 0;

  always #2.5 clk = ~clk;

  rowperm_top u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .inv_i  (inv_r),
    .state_i(st_r),
    .state_o(state_o)
  );

  // {inv, input, expected}
  localparam int NV = 7;
  localparam logic [256:0] VEC [NV] = '{
    {1'b0, 128'h0f0e0d0c0b0a09080706050403020100, 128'h0f06090c0b020508070e0104030a0d00},  // R3
    {1'b0, 128'h5f5d5b5957555351_4f4d4b4947454341, 128'h575d43594f555b51474d53495f454b41},  // R4
    {1'b1, 128'h0f0e0d0c0b0a09080706050403020100, 128'h0f06010c0b020d08070e0904030a0500},  // R5
    {1'b1, 128'h5f5d5b5957555351_4f4d4b4947454341, 128'h475d53595f554b51574d43494f455b41},  // R6
    {1'b0, {16{8'ha5}}, {16{8'ha5}}},                                                   // R8
    {1'b1, {16{8'ha5}}, {16{8'ha5}}},                                                   // R8
    {1'b0, 128'h0000_0000_0000_0000_0000_0000_0000_ff00,
           128'h0000_0000_0000_0000_0000_ff00_0000_0000}                                // R1
  };
  localparam string VTAG [NV] = '{"R3", "R4", "R5", "R6", "R8", "R8", "R1"};

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %032h expected %032h", tag, got, exp);
    end
  endtask

  task automatic run(input logic inv, input logic [127:0] s, output logic [127:0] res);
    @(negedge clk);
    inv_r = inv;
    st_r  = s;
    @(negedge clk);
    res = state_o;
  endtask

  // model: source byte (r,c) goes to column (c - left) mod 4
  function automatic logic [127:0] model(input logic [127:0] s, input logic inv);
    logic [127:0] o;
    int lft [4];
    lft = '{0, 0, 0, 0};
    if (s[0]) begin lft[1] = 1; lft[3] = 3; end
    else      begin lft[1] = -1; lft[2] = -2; end
    o = '0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        int l;
        int d;
        l = inv ? -lft[r] : lft[r];
        d = ((c - l) % 4 + 4) % 4;
        o[8*(4*d+r) +: 8] = s[8*(4*c+r) +: 8];
      end
    return o;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] res;
    logic [127:0] fw;
    logic [127:0] s;
    repeat (3) @(negedge clk);
    st_r = 128'hdeadbeef_01234567_89abcdef_55aa55aa;
    @(negedge clk);
    check("R9 reset value", state_o, '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][256], VEC[i][255:128], res);
      check(VTAG[i], res, VEC[i][127:0]);
    end

    for (int i = 0; i < 40; i++) begin
      s = {$urandom, $urandom, $urandom, $urandom};
      if (i % 2 == 0) s[0] = ~s[0];
      run(1'b0, s, fw);
      check(s[0] ? "R4 random fwd" : "R3 random fwd", fw, model(s, 1'b0));
      check("R2 row0 kept", {fw[103:96], fw[71:64], fw[39:32], fw[7:0]},
            {s[103:96], s[71:64], s[39:32], s[7:0]});
      run(1'b1, fw, res);
      check("R7 round trip", res, s);
      run(1'b1, s, res);
      check(s[0] ? "R6 random inv" : "R5 random inv", res, model(s, 1'b1));
    end

    // R9: latency of one edge and hold between edges
    run(1'b0, 128'h0f0e0d0c0b0a09080706050403020100, res);
    @(negedge clk);
    st_r = {16{8'h3c}};
    #1;
    check("R9 holds before edge", state_o, 128'h0f06090c0b020508070e0104030a0d00);
    @(negedge clk);
    check("R9 updates after edge", state_o, {16{8'h3c}});

    // R9: asynchronous clear mid-run
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check("R9 async clear", state_o, '0);
    @(negedge clk);
    check("R9 held in reset", state_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after release", state_o, {16{8'h3c}});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule